// File: doc/BRIEF.md
# Unified Multi-Port Micro-Operation Scheduler

This block is the shared reservation station between rename and the execution ports. A single 60-entry pool holds micro-operations of every class. Each entry keeps an operation class, a destination tag, two source tags with their ready bits, and its place in age order. A completion bus broadcasts destination tags. Every matching source in the pool becomes ready, and entries being inserted in the same cycle also see the broadcast.

Every cycle the picker serves eight dispatch ports. Port 0 chooses first and port 7 last. Each port takes the oldest entry that is ready, is allowed on that port by the fixed class-to-port map, and has not already been taken by a lower-numbered port. Four ports serve compute classes and four serve memory classes. A port whose busy input is high takes nothing that cycle. A dispatched entry leaves the pool on the next clock edge, and the entries that remain keep their relative age.

Rename offers a group of up to four micro-operations per cycle. Slot 0 of the group is the oldest. The whole group is refused when it needs more entries than are currently free, and the block raises a stall signal back to rename.

Top module: `uop_sched`

## Requirements
- R1: The pool holds up to 60 entries of any mix of classes. When 60 are held, no further entry is accepted.
- R2: Each cycle at most one entry is dispatched per port, across eight ports. No entry is dispatched on two ports. A dispatched entry is removed at the next clock edge and is never dispatched again.
- R3: Ports choose in ascending order from 0 to 7. Each port takes the oldest ready, eligible entry not yet taken by a lower port. Age is insertion order, and within one group a lower slot is older.
- R4: Class codes map to ports as follows. 0 is integer ALU and may use ports 0, 1, 5 and 6. 1 is branch and may use ports 0 and 6. 2 is vector/FP and may use ports 0, 1 and 5. 3 is load and may use ports 2 and 3. 4 is store address and may use ports 2, 3 and 7. 5 is store data and may use port 4 only. Codes 6 and 7 behave as code 0.
- R5: An entry is ready when both source ready bits are set. A ready bit is set at insertion by the supplied flag or by a matching broadcast in that same cycle, or later by a matching broadcast. An entry can first be dispatched in the cycle after its last ready bit was set.
- R6: A port whose busy bit is high dispatches nothing in that cycle. The entries it would have taken stay in the pool with their age unchanged.
- R7: `ins_stall` is high in the same cycle exactly when the number of free entries is below the number of set bits in `ins_valid`. A stalled group inserts nothing.
- R8: Entries freed by dispatch in a cycle do not count as free until the next cycle.
- R9: After reset the pool is empty. No port dispatches, and a full group of four is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | INS_W | Valid bit per insert slot |
| ins_cls | input | 3*INS_W | Class code per slot |
| ins_dst | input | TAG_W*INS_W | Destination tag per slot |
| ins_srca | input | TAG_W*INS_W | First source tag per slot |
| ins_srcb | input | TAG_W*INS_W | Second source tag per slot |
| ins_rdya | input | INS_W | First source already ready |
| ins_rdyb | input | INS_W | Second source already ready |
| ins_stall | output | 1 | Group refused this cycle |
| wb_valid | input | WB_N | Valid bit per broadcast lane |
| wb_tag | input | TAG_W*WB_N | Completed destination tag per lane |
| port_busy | input | 8 | Per-port resource unavailable |
| disp_valid | output | 8 | Per-port dispatch this cycle |
| disp_cls | output | 24 | Class of dispatched entry per port |
| disp_dst | output | 8*TAG_W | Destination tag of dispatched entry per port |

## Verification
Several properties are checked on every cycle. A busy port is idle, every dispatch is legal for its port, no entry appears on two ports, only entries with both ready bits are picked, the count never passes capacity, and a stalled cycle never grows the pool. Other behaviour can only be shown by the bench's scenarios against its reference queue. This covers which entry each port gets under age order, the one-cycle gap between wakeup and dispatch, the refusal of a group while a dispatch is freeing an entry, and the fill of all eight ports in one cycle.

// File: rtl/uop_sched.sv
module uop_sched #(
  parameter int ENTRIES = 60,
  parameter int TAG_W   = 7,
  parameter int INS_W   = 4,
  parameter int WB_N    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [INS_W-1:0]         ins_valid,
  input  logic [3*INS_W-1:0]       ins_cls,
  input  logic [TAG_W*INS_W-1:0]   ins_dst,
  input  logic [TAG_W*INS_W-1:0]   ins_srca,
  input  logic [TAG_W*INS_W-1:0]   ins_srcb,
  input  logic [INS_W-1:0]         ins_rdya,
  input  logic [INS_W-1:0]         ins_rdyb,
  output logic                     ins_stall,
  input  logic [WB_N-1:0]          wb_valid,
  input  logic [TAG_W*WB_N-1:0]    wb_tag,
  input  logic [7:0]               port_busy,
  output logic [7:0]               disp_valid,
  output logic [23:0]              disp_cls,
  output logic [8*TAG_W-1:0]       disp_dst
);
  localparam int NP    = 8;
  localparam int CNT_W = $clog2(ENTRIES + 1);
  localparam int IDX_W = $clog2(ENTRIES);

  function automatic logic [NP-1:0] port_mask(input logic [2:0] c);
    case (c)
      3'd1:    port_mask = 8'h41;
      3'd2:    port_mask = 8'h23;
      3'd3:    port_mask = 8'h0C;
      3'd4:    port_mask = 8'h8C;
      3'd5:    port_mask = 8'h10;
      default: port_mask = 8'h63;
    endcase
  endfunction

  function automatic logic tag_hit(input logic [TAG_W-1:0] t,
                                   input logic [WB_N-1:0] v,
                                   input logic [TAG_W*WB_N-1:0] tg);
    tag_hit = 1'b0;
    for (int w = 0; w < WB_N; w++)
      if (v[w] && tg[w*TAG_W +: TAG_W] == t) tag_hit = 1'b1;
  endfunction

  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [2:0]         cls_q [ENTRIES];
  logic [2:0]         cls_d [ENTRIES];
  logic [TAG_W-1:0]   dst_q [ENTRIES];
  logic [TAG_W-1:0]   dst_d [ENTRIES];
  logic [TAG_W-1:0]   sa_q  [ENTRIES];
  logic [TAG_W-1:0]   sa_d  [ENTRIES];
  logic [TAG_W-1:0]   sb_q  [ENTRIES];
  logic [TAG_W-1:0]   sb_d  [ENTRIES];
  logic [ENTRIES-1:0] ra_q, ra_d, rb_q, rb_d;
  logic [ENTRIES-1:0] live, cand, taken;
  logic [NP-1:0]      elig_q [ENTRIES];
  logic [ENTRIES-1:0] pick [NP];
  logic [IDX_W-1:0]   sel  [NP];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign live[g]   = (CNT_W'(g) < cnt_q);
    assign elig_q[g] = port_mask(cls_q[g]);
  end
  assign cand = live & ra_q & rb_q;

  always_comb begin
    taken = '0;
    for (int p = 0; p < NP; p++) begin
      pick[p] = '0;
      sel[p]  = '0;
      for (int i = 0; i < ENTRIES; i++)
        if (!port_busy[p] && pick[p] == '0 && cand[i] && !taken[i] && elig_q[i][p]) begin
          pick[p][i] = 1'b1;
          sel[p]     = IDX_W'(i);
        end
      taken = taken | pick[p];
    end
  end

  for (genvar gp = 0; gp < NP; gp++) begin : g_port
    assign disp_valid[gp]               = |pick[gp];
    assign disp_cls[gp*3 +: 3]          = cls_q[sel[gp]];
    assign disp_dst[gp*TAG_W +: TAG_W]  = dst_q[sel[gp]];
  end

  assign ins_stall = (ENTRIES - int'(cnt_q)) < $countones(ins_valid);

  always_comb begin
    int k;
    k = 0;
    for (int i = 0; i < ENTRIES; i++) begin
      cls_d[i] = cls_q[i];
      dst_d[i] = dst_q[i];
      sa_d[i]  = sa_q[i];
      sb_d[i]  = sb_q[i];
      ra_d[i]  = 1'b0;
      rb_d[i]  = 1'b0;
    end
    for (int i = 0; i < ENTRIES; i++)
      if (live[i] && !taken[i]) begin
        cls_d[k] = cls_q[i];
        dst_d[k] = dst_q[i];
        sa_d[k]  = sa_q[i];
        sb_d[k]  = sb_q[i];
        ra_d[k]  = ra_q[i] | tag_hit(sa_q[i], wb_valid, wb_tag);
        rb_d[k]  = rb_q[i] | tag_hit(sb_q[i], wb_valid, wb_tag);
        k++;
      end
    if (!ins_stall)
      for (int s = 0; s < INS_W; s++)
        if (ins_valid[s] && k < ENTRIES) begin
          cls_d[k] = ins_cls[s*3 +: 3];
          dst_d[k] = ins_dst[s*TAG_W +: TAG_W];
          sa_d[k]  = ins_srca[s*TAG_W +: TAG_W];
          sb_d[k]  = ins_srcb[s*TAG_W +: TAG_W];
          ra_d[k]  = ins_rdya[s] | tag_hit(ins_srca[s*TAG_W +: TAG_W], wb_valid, wb_tag);
          rb_d[k]  = ins_rdyb[s] | tag_hit(ins_srcb[s*TAG_W +: TAG_W], wb_valid, wb_tag);
          k++;
        end
    cnt_d = CNT_W'(k);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ra_q  <= '0;
      rb_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      ra_q  <= ra_d;
      rb_q  <= rb_d;
    end
  end

  always_ff @(posedge clk) begin
    cls_q <= cls_d;
    dst_q <= dst_d;
    sa_q  <= sa_d;
    sb_q  <= sb_d;
  end

  for (genvar gp = 0; gp < NP; gp++) begin : g_chk_port
    logic [NP-1:0] om;
    assign om = port_mask(disp_cls[gp*3 +: 3]);
    a_r6_busy_idle: assert property (@(posedge clk) disable iff (!rst_n)
      port_busy[gp] |-> !disp_valid[gp]);
    a_r4_port_map: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid[gp] |-> om[gp]);
  end

  for (genvar ge = 0; ge < ENTRIES; ge++) begin : g_chk_ent
    logic [NP-1:0] col;
    for (genvar gq = 0; gq < NP; gq++) begin : g_col
      assign col[gq] = pick[gq][ge];
    end
    a_r2_one_port: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(col) <= 1);
    a_r5_ready_only: assert property (@(posedge clk) disable iff (!rst_n)
      (|col) |-> (ra_q[ge] && rb_q[ge] && live[ge]));
  end

  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(ENTRIES));
  a_r7_stall_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    ins_stall |=> cnt_q <= $past(cnt_q));
endmodule

// File: tb/sim_uop_sched.sv
module sim_uop_sched;
  localparam int TW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    ins_valid, ins_rdya, ins_rdyb;
  logic [11:0]   ins_cls;
  logic [4*TW-1:0] ins_dst, ins_srca, ins_srcb;
  logic          ins_stall;
  logic [3:0]    wb_valid;
  logic [4*TW-1:0] wb_tag;
  logic [7:0]    port_busy, disp_valid;
  logic [23:0]   disp_cls;
  logic [8*TW-1:0] disp_dst;

  uop_sched u0 (.clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_cls(ins_cls),
    .ins_dst(ins_dst), .ins_srca(ins_srca), .ins_srcb(ins_srcb), .ins_rdya(ins_rdya),
    .ins_rdyb(ins_rdyb), .ins_stall(ins_stall), .wb_valid(wb_valid), .wb_tag(wb_tag),
    .port_busy(port_busy), .disp_valid(disp_valid), .disp_cls(disp_cls), .disp_dst(disp_dst));

  always #5 clk = ~clk;

  typedef struct { int cls; int dst; int sa; int sb; bit ra; bit rb; } ent_t;
  ent_t  q[$];
  int    checks = 0;
  int    fails = 0;
  string cur_req = "R3";

  task automatic chk(bit cond, string req, int act, int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit ok(int c, int p);
    case (c)
      1: return p == 0 || p == 6;
      2: return p == 0 || p == 1 || p == 5;
      3: return p == 2 || p == 3;
      4: return p == 2 || p == 3 || p == 7;
      5: return p == 4;
      default: return p == 0 || p == 1 || p == 5 || p == 6;
    endcase
  endfunction

  function automatic bit hit(int t);
    for (int w = 0; w < 4; w++)
      if (wb_valid[w] && int'(wb_tag[w*TW +: TW]) == t) return 1'b1;
    return 1'b0;
  endfunction

  task automatic clr();
    ins_valid = '0; ins_rdya = '0; ins_rdyb = '0; ins_cls = '0;
    ins_dst = '0; ins_srca = '0; ins_srcb = '0;
    wb_valid = '0; wb_tag = '0; port_busy = '0;
  endtask

  task automatic put(int s, int c, int d, int a, int b, bit ra, bit rb);
    ins_valid[s] = 1'b1;
    ins_cls[s*3 +: 3] = 3'(c);
    ins_dst[s*TW +: TW] = TW'(d);
    ins_srca[s*TW +: TW] = TW'(a);
    ins_srcb[s*TW +: TW] = TW'(b);
    ins_rdya[s] = ra;
    ins_rdyb[s] = rb;
  endtask

  task automatic bc(int l, int t);
    wb_valid[l] = 1'b1;
    wb_tag[l*TW +: TW] = TW'(t);
  endtask

  task automatic step();
    bit   tk[64];
    int   n, ep;
    bit   est;
    ent_t nq[$];
    ent_t e;
    n = q.size();
    for (int i = 0; i < 64; i++) tk[i] = 1'b0;
    est = (60 - n) < $countones(ins_valid);
    chk(ins_stall === est, "R7", int'(ins_stall), int'(est));
    for (int p = 0; p < 8; p++) begin
      ep = -1;
      if (!port_busy[p])
        for (int i = 0; i < n; i++)
          if (q[i].ra && q[i].rb && !tk[i] && ok(q[i].cls, p)) begin
            ep = i; tk[i] = 1'b1; break;
          end
      chk(disp_valid[p] === (ep >= 0), cur_req, int'(disp_valid[p]), int'(ep >= 0));
      if (ep >= 0 && disp_valid[p] === 1'b1) begin
        chk(int'(disp_cls[p*3 +: 3]) == q[ep].cls, cur_req, int'(disp_cls[p*3 +: 3]), q[ep].cls);
        chk(int'(disp_dst[p*TW +: TW]) == q[ep].dst, cur_req, int'(disp_dst[p*TW +: TW]), q[ep].dst);
      end
    end
    for (int i = 0; i < n; i++)
      if (!tk[i]) begin
        e = q[i];
        e.ra = e.ra | hit(e.sa);
        e.rb = e.rb | hit(e.sb);
        nq.push_back(e);
      end
    if (!est)
      for (int s = 0; s < 4; s++)
        if (ins_valid[s]) begin
          e.cls = int'(ins_cls[s*3 +: 3]);
          e.dst = int'(ins_dst[s*TW +: TW]);
          e.sa  = int'(ins_srca[s*TW +: TW]);
          e.sb  = int'(ins_srcb[s*TW +: TW]);
          e.ra  = ins_rdya[s] | hit(e.sa);
          e.rb  = ins_rdyb[s] | hit(e.sb);
          nq.push_back(e);
        end
    q = nq;
    @(negedge clk);
  endtask

  task automatic go();
    #1;
    step();
  endtask

  task automatic drain();
    for (int c = 0; c < 40; c++) begin
      clr();
      for (int l = 0; l < 4; l++) bc(l, (c * 4 + l) % 128);
      go();
    end
    for (int c = 0; c < 100 && q.size() > 0; c++) begin
      clr();
      go();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    clr();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 and R1: fill the pool with unready entries
    for (int g = 0; g < 15; g++) begin
      clr();
      for (int s = 0; s < 4; s++) begin
        int i = g * 4 + s;
        put(s, i % 6, i, i, 64 + i, 1'b0, 1'b0);
      end
      #1;
      if (g == 0) begin
        chk(disp_valid === 8'h00, "R9", int'(disp_valid), 0);
        chk(ins_stall === 1'b0, "R9", int'(ins_stall), 0);
      end
      step();
    end
    clr(); put(0, 0, 100, 1, 1, 1'b1, 1'b1);
    #1; chk(ins_stall === 1'b1, "R1", int'(ins_stall), 1); step();
    // R8: dispatch in same cycle does not free room
    clr(); bc(0, 0); bc(1, 64); put(0, 0, 100, 1, 1, 1'b1, 1'b1);
    #1; chk(disp_valid === 8'h00, "R5", int'(disp_valid), 0); step();
    clr(); put(0, 0, 100, 1, 1, 1'b1, 1'b1);
    #1;
    chk(disp_valid[0] === 1'b1, "R5", int'(disp_valid[0]), 1);
    chk(ins_stall === 1'b1, "R8", int'(ins_stall), 1);
    step();
    clr(); put(0, 0, 100, 1, 1, 1'b1, 1'b1);
    #1; chk(ins_stall === 1'b0, "R8", int'(ins_stall), 0); step();
    cur_req = "R3";
    drain();
    chk(q.size() == 0, "R3", q.size(), 0);
    // R2: all eight ports in one cycle
    cur_req = "R2";
    clr(); for (int s = 0; s < 4; s++) put(s, 0, 10 + s, 20, 0, 1'b0, 1'b1); go();
    clr(); put(0, 3, 14, 20, 0, 1'b0, 1'b1); put(1, 3, 15, 20, 0, 1'b0, 1'b1);
    put(2, 4, 16, 20, 0, 1'b0, 1'b1); put(3, 5, 17, 20, 0, 1'b0, 1'b1); go();
    clr(); bc(0, 20);
    #1; chk(disp_valid === 8'h00, "R5", int'(disp_valid), 0); step();
    clr(); #1; chk(disp_valid === 8'hFF, "R2", int'(disp_valid), 255); step();
    clr(); #1; chk(disp_valid === 8'h00, "R2", int'(disp_valid), 0); step();
    // R5: wakeup arriving with the insert
    cur_req = "R5";
    clr(); put(0, 0, 30, 33, 0, 1'b0, 1'b1); bc(0, 33); go();
    clr(); #1; chk(disp_valid === 8'h01, "R5", int'(disp_valid), 1); step();
    // R4: branch ports and reserved code
    cur_req = "R4";
    clr(); for (int s = 0; s < 3; s++) put(s, 1, 40 + s, 0, 0, 1'b1, 1'b1); go();
    clr(); #1; chk(disp_valid === 8'h41, "R4", int'(disp_valid), 65); step();
    clr(); #1; chk(disp_valid === 8'h01, "R4", int'(disp_valid), 1); step();
    clr(); put(0, 7, 45, 0, 0, 1'b1, 1'b1); go();
    clr(); port_busy = 8'h23;
    #1; chk(disp_valid === 8'h40, "R4", int'(disp_valid), 64); step();
    // R3: age order through a single free port
    cur_req = "R3";
    clr(); put(0, 0, 11, 0, 0, 1'b1, 1'b1); put(1, 0, 12, 0, 0, 1'b1, 1'b1); go();
    clr(); port_busy = 8'h62;
    #1; chk(int'(disp_dst[TW-1:0]) == 11, "R3", int'(disp_dst[TW-1:0]), 11); step();
    clr(); port_busy = 8'h62;
    #1; chk(int'(disp_dst[TW-1:0]) == 12, "R3", int'(disp_dst[TW-1:0]), 12); step();
    // R6: busy ports hold entries
    cur_req = "R6";
    clr(); put(0, 0, 50, 0, 0, 1'b1, 1'b1); go();
    for (int c = 0; c < 3; c++) begin
      clr(); port_busy = 8'hFF;
      #1; chk(disp_valid === 8'h00, "R6", int'(disp_valid), 0); step();
    end
    clr(); #1; chk(disp_valid === 8'h01, "R6", int'(disp_valid), 1); step();
    // mixed random traffic against the reference queue
    cur_req = "R3";
    for (int c = 0; c < 4000; c++) begin
      clr();
      for (int s = 0; s < 4; s++)
        if ($urandom % 3 != 0)
          put(s, int'($urandom % 8), int'($urandom % 128), int'($urandom % 128),
              int'($urandom % 128), ($urandom % 2) == 0, ($urandom % 3) != 0);
      for (int l = 0; l < 4; l++)
        if ($urandom % 2 == 0) bc(l, int'($urandom % 128));
      port_busy = 8'($urandom & $urandom);
      go();
    end
    drain();
    chk(q.size() == 0, "R2", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule